// File: doc/BRIEF.md
# Two-Section Truncatable Ripple-Style Counter

This block is a four-bit binary counter split into two stages that count on their own. The low stage is a single bit that flips on every falling edge of its own count input. The high stage is a three-bit up counter that steps on every falling edge of a second count input. Both count inputs are sampled on one system clock. A falling edge, meaning the previous sample was 1 and the present one is 0, acts as a clock enable for its stage. No signal is used as a real clock.

The two stages form a full four-bit counter in either of two ways. The low bit can be wired outside the block to the high stage's count input. The `link_mode` input can be raised instead. In that mode the high stage steps in the same system cycle in which the low bit falls from 1 to 0.

Two clear inputs are ANDed together. When both are high, all four bits go to zero. Wiring chosen output bits back onto the two clear inputs ends the count early. With bit 0 and bit 3 fed back, the counter runs from 0 to 8 and then returns to 0.

Top module: `tc_split_counter`

## Requirements
- R1: A synchronous `rst` drives `count_q` to 0 at the next clock edge. It also loads 0 into both count-input history samples, so the first cycle after reset cannot produce a falling edge.
- R2: `count_q[0]` inverts at the clock edge in which `cnt_a_in` samples 0 after having sampled 1. Steady levels and rising edges leave it unchanged.
- R3: With `link_mode` low, `count_q[3:1]` is a binary value with `count_q[1]` as its least significant bit. It increments by one, modulo 8, at the clock edge in which `cnt_b_in` samples 0 after 1.
- R4: With `link_mode` high, `count_q[3:1]` increments at the same clock edge in which `count_q[0]` goes from 1 to 0, and `cnt_b_in` has no effect.
- R5: In linked counting the four-bit value wraps from 15 to 0 on the next falling edge of `cnt_a_in`.
- R6: When `clr_a` and `clr_b` are both high at a clock edge, `count_q` becomes 0 at that edge, whatever count edges are present.
- R7: With only one of `clr_a` and `clr_b` high, counting proceeds exactly as if neither were high.
- R8: In linked mode, with `clr_a` tied to `count_q[0]` and `clr_b` tied to `count_q[3]`, the outputs run 0 to 8. Value 9 is visible for exactly one system clock, and the next value is 0. No value above 9 appears.
- R9: In unlinked mode, a falling edge on one section's count input never changes the other section's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_a_in | input | 1 | Count input of the one-bit stage (falling edge steps) |
| cnt_b_in | input | 1 | Count input of the three-bit stage (falling edge steps) |
| link_mode | input | 1 | 1: the high stage is stepped internally by the low bit falling |
| clr_a | input | 1 | Clear request, first leg of the AND |
| clr_b | input | 1 | Clear request, second leg of the AND |
| count_q | output | B_W+1 | Registered count: bit 0 from the low stage, upper bits from the high stage |

## Verification
A wrong bit in either stage shows on `count_q` at the very next sample, because every output is a register. A lost or extra edge appears as one step of divergence from the reference model in that same cycle. A fault in the link path first shows when the low bit falls: the high stage then fails to advance, or advances late. A fault in the clear AND shows in truncation as a 9 held for two samples or as values above 9, and the trace checks for both.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2
  } sec_act_e;

  // clear always outranks a step
  function automatic sec_act_e pick_act(input logic clear, input logic step);
    if (clear)     return ACT_CLEAR;
    else if (step) return ACT_STEP;
    else           return ACT_HOLD;
  endfunction

endpackage

// File: rtl/tc_fall_detect.sv
module tc_fall_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl[i];
      end
      assign fall[i] = prev_q & ~lvl[i];
    end
  endgenerate

endmodule

// File: rtl/tc_section.sv
module tc_section
  import tcnt_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  sec_act_e     act,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q_r;
  logic [W-1:0] nxt;

  generate
    if (W == 1) begin : g_toggle
      assign nxt = ~q_r;
    end else begin : g_incr
      assign nxt = q_r + ONE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      case (act)
        ACT_CLEAR: q_r <= '0;
        ACT_STEP:  q_r <= nxt;
        default:   q_r <= q_r;
      endcase
    end
  end

  assign q = q_r;

endmodule

// File: rtl/tc_split_counter.sv
module tc_split_counter
  import tcnt_pkg::*;
#(
  parameter  int B_W   = 3,
  localparam int CNT_W = B_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_a_in,
  input  logic             cnt_b_in,
  input  logic             link_mode,
  input  logic             clr_a,
  input  logic             clr_b,
  output logic [CNT_W-1:0] count_q
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] lvl;
  logic [N_IN-1:0] fall;
  logic            clear;
  logic            step_b;
  logic            qa;
  logic [B_W-1:0]  qb;
  sec_act_e        act_a;
  sec_act_e        act_b;

  assign lvl = {cnt_b_in, cnt_a_in};

  tc_fall_detect #(.N(N_IN)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl),
    .fall (fall)
  );

  assign clear  = clr_a & clr_b;
  // linked: high stage steps exactly when the low bit drops 1 -> 0
  assign step_b = link_mode ? (fall[0] & qa) : fall[1];
  assign act_a  = pick_act(clear, fall[0]);
  assign act_b  = pick_act(clear, step_b);

  logic [0:0] qa_v;

  tc_section #(.W(1)) sec_a_i (
    .clk (clk),
    .rst (rst),
    .act (act_a),
    .q   (qa_v)
  );

  tc_section #(.W(B_W)) sec_b_i (
    .clk (clk),
    .rst (rst),
    .act (act_b),
    .q   (qb)
  );

  assign qa      = qa_v[0];
  assign count_q = {qb, qa};

endmodule

// File: rtl/tc_split_counter_chk.sv
module tc_split_counter_chk #(
  parameter int B_W = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           cnt_a_in,
  input logic           cnt_b_in,
  input logic           link_mode,
  input logic           clr_a,
  input logic           clr_b,
  input logic [B_W:0]   count_q
);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b) |=> (count_q == '0));

  assert_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_a_in) && !cnt_a_in && !(clr_a && clr_b))
      |=> (count_q[0] != $past(count_q[0])));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!($past(cnt_a_in) && !cnt_a_in) && !(clr_a && clr_b))
      |=> (count_q[0] == $past(count_q[0])));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !link_mode && $past(cnt_b_in) && !cnt_b_in && !(clr_a && clr_b))
      |=> (count_q[B_W:1] == B_W'($past(count_q[B_W:1]) + 1'b1)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && link_mode && (count_q == '1) && $past(cnt_a_in) && !cnt_a_in
      && !(clr_a && clr_b))
      |=> (count_q == '0));

endmodule

bind tc_split_counter tc_split_counter_chk #(.B_W(B_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cnt_a_in  (cnt_a_in),
  .cnt_b_in  (cnt_b_in),
  .link_mode (link_mode),
  .clr_a     (clr_a),
  .clr_b     (clr_b),
  .count_q   (count_q)
);

// File: tb/tc_split_counter_tb_top.sv
module tc_split_counter_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_in = 1'b0, b_in = 1'b0, link = 1'b0;
  logic ca_drv = 1'b0, cb_drv = 1'b0, trunc = 1'b0;
  logic clr_a, clr_b;
  logic [3:0] q;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_qa = 0, m_qb = 0, m_pa = 0, m_pb = 0;

  always #5 clk = ~clk;

  assign clr_a = trunc ? q[0] : ca_drv;
  assign clr_b = trunc ? q[3] : cb_drv;

  tc_split_counter dut_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_a_in  (a_in),
    .cnt_b_in  (b_in),
    .link_mode (link),
    .clr_a     (clr_a),
    .clr_b     (clr_b),
    .count_q   (q)
  );

  function automatic int m_val();
    return m_qb * 2 + m_qa;
  endfunction

  // one system cycle: inputs applied now (after negedge), compared at next negedge
  task automatic step(input logic a, input logic b, input string tag);
    int ca, cb, fa, fb, na, nb;
    a_in = a; b_in = b;
    ca = trunc ? m_qa : int'(ca_drv);
    cb = trunc ? (m_qb / 4) : int'(cb_drv);
    if (rst) begin
      na = 0; nb = 0; m_pa = 0; m_pb = 0;
    end else begin
      fa = (m_pa == 1 && a == 1'b0) ? 1 : 0;
      fb = (m_pb == 1 && b == 1'b0) ? 1 : 0;
      na = m_qa; nb = m_qb;
      if (ca == 1 && cb == 1) begin
        na = 0; nb = 0;
      end else begin
        if (fa == 1) na = 1 - m_qa;
        if (link ? (fa == 1 && m_qa == 1) : (fb == 1)) nb = (m_qb + 1) % 8;
      end
      m_pa = int'(a); m_pb = int'(b);
    end
    m_qa = na; m_qb = nb;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (int'(q) != m_val()) begin
      errors++;
      $display("FAIL %s: count_q=%0d expected %0d", tag, q, m_val());
    end
  endtask

  task automatic pulse_a(input logic b, input string tag);
    step(1'b1, b, tag);
    step(1'b0, b, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen9;
    int maxv;
    @(negedge clk);
    // R1: reset with count inputs busy
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, "R1");
    rst = 1'b0;
    step(1'b0, 1'b0, "R1");

    // R2 and R9: low stage alone, high stage idle
    for (int i = 0; i < 5; i++) pulse_a(1'b0, "R2/R9");
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");

    // R3 and R9: high stage alone, wrapping past 7
    step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1, "R3/R9");
      step(1'b0, 1'b0, "R3/R9");
    end

    // R7: one clear leg at a time
    ca_drv = 1'b1;
    for (int i = 0; i < 3; i++) pulse_a(1'b0, "R7");
    ca_drv = 1'b0; cb_drv = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, "R7");
      step(1'b0, 1'b0, "R7");
    end

    // R6: both legs high while edges arrive
    ca_drv = 1'b1;
    step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, "R6");
    ca_drv = 1'b0; cb_drv = 1'b0;
    step(1'b0, 1'b0, "R6");

    // R4 and R5: linked, cnt_b_in toggled to prove it is ignored
    link = 1'b1;
    for (int i = 0; i < 20; i++) pulse_a(1'(i % 2), "R4/R5");

    // R8: truncation through feedback of bits 0 and 3
    ca_drv = 1'b1; cb_drv = 1'b1;
    step(1'b0, 1'b0, "R6");
    ca_drv = 1'b0; cb_drv = 1'b0;
    trunc = 1'b1;
    seen9 = 0; maxv = 0;
    for (int i = 0; i < 50; i++) begin
      step(1'(i % 2 == 0), 1'b0, "R8");
      if (int'(q) > maxv) maxv = int'(q);
      if (seen9 == 1) begin
        checks++;
        if (q != 4'd0) begin
          errors++;
          $display("FAIL R8: value after 9 is %0d expected 0", q);
        end
      end
      seen9 = (q == 4'd9) ? 1 : 0;
    end
    checks++;
    if (maxv != 9) begin
      errors++;
      $display("FAIL R8: peak value %0d expected 9", maxv);
    end
    trunc = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule